// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits at the instruction boundary of an 8-bit CPU core. When the core reaches the end of an instruction, it pulses `step_i` and reports what that instruction was: an enable, a disable, a halt, or a write of the interrupt mode. From these reports the block keeps its own state: the two interrupt-enable flags, the interrupt mode, the halt latch and the one-instruction shadow that follows an enable. It then picks one outcome for the boundary. The outcome is an ordinary opcode fetch, an internal no-op while halted, a device-supplied instruction (mode 0), or a full acceptance sequence. A full sequence serves the non-maskable request, mode 1 or mode 2.

An acceptance sequence runs on a small bus-request port, one byte transfer at a time. It can do a dummy opcode fetch, push the return address onto the stack, read a vector byte from the interrupting device, and read a 16-bit handler address from a table that the I register indexes. When the sequence ends, the block pulses `done_o` and returns the new PC, the new stack pointer, the updated refresh register and a T-state count. Opcode decode and the datapath remain the core's job.

Top module: `irq_accept_seq`

## Requirements
- R1: A pending non-maskable request wins over a maskable one. The non-maskable line is edge-latched: each rising edge of `nmi_req_i` gives exactly one acceptance. Holding the line high gives no second acceptance until the line falls and rises again.
- R2: A maskable request (`int_req_i` high at a boundary) is accepted only if IFF1 is set after the completed instruction is applied and that instruction was not an enable (`ei_done_i`).
- R3: Accepting any interrupt (outcome codes 2 to 5) clears the halt latch (`halted_o` = 0).
- R4: A non-maskable acceptance first does a dummy opcode fetch (bus op 3) at the current PC, then pushes PC. It sets PC to 0x0066, reports 11 T-states, clears IFF1 and leaves IFF2 unchanged. Its outcome code is 2.
- R5: A mode-1 acceptance pushes PC, sets PC to 0x0038 and reports 13 T-states, with no device read. Its outcome code is 3.
- R6: Bus op codes are 0 memory read, 1 memory write, 2 device vector read and 3 opcode fetch. A push writes the PC high byte to SP-1 first, then the low byte to SP-2, and `sp_o` returns SP-2. A request holds its op and address steady until `bus_ack_i`.
- R7: A mode-2 acceptance pushes PC and then reads the device byte (op 2). It forms the table address as I in the upper byte and the device byte with bit 0 cleared in the lower byte. It reads the new PC low byte from that address and the high byte from the next address, and reports 19 T-states. Its outcome code is 4.
- R8: A mode-0 acceptance makes no bus request. It returns outcome code 5, PC unchanged and a count of 2, which is the extra wait states the device-supplied fetch takes.
- R9: On any acceptance, bits 6:0 of the refresh value go up by one and wrap, and bit 7 keeps its value. On fetch and halt outcomes, `r_o` equals `r_i`.
- R10: After reset both enable flags are 0 and the mode is 0. A disable clears both flags, an enable sets both, and a maskable acceptance clears both.
- R11: A boundary that reports a halt, or any boundary while halted with no acceptance, returns outcome 1. Outcome 1 leaves PC unchanged and reports 4 T-states. The halt latch stays set until an interrupt is accepted.
- R12: A mode write with value 0, 1 or 2 sets the mode. Value 3 is ignored and the mode is left as it was.
- R13: Boundaries with no acceptance and no halt return outcome 0 with a count of 0, and they pulse `done_o` on the cycle after `step_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction boundary reached (taken while not busy) |
| nmi_req_i | input | 1 | Non-maskable request line (edge-latched) |
| int_req_i | input | 1 | Maskable request line (level) |
| ei_done_i | input | 1 | Completed instruction was an enable |
| di_done_i | input | 1 | Completed instruction was a disable |
| halt_done_i | input | 1 | Completed instruction was a halt |
| im_wr_i | input | 1 | Completed instruction writes the interrupt mode |
| im_val_i | input | 2 | Mode value for `im_wr_i` |
| pc_i | input | 16 | Current PC |
| sp_i | input | 16 | Current stack pointer |
| i_reg_i | input | 8 | Vector table page register |
| r_i | input | 8 | Current refresh register |
| bus_req_o | output | 1 | Byte transfer requested |
| bus_op_o | output | 2 | Transfer kind (R6 codes) |
| bus_addr_o | output | 16 | Transfer address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transfer complete |
| bus_rdata_i | input | 8 | Read data, valid with `bus_ack_i` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: outcome and results valid |
| outcome_o | output | 3 | 0 fetch, 1 halt no-op, 2 NMI, 3 mode 1, 4 mode 2, 5 mode 0 |
| pc_o | output | 16 | New PC |
| sp_o | output | 16 | New stack pointer |
| r_o | output | 8 | New refresh register |
| tstates_o | output | 5 | T-states of the outcome |
| iff1_o | output | 1 | Enable flag 1 |
| iff2_o | output | 1 | Enable flag 2 |
| im_o | output | 2 | Interrupt mode |
| halted_o | output | 1 | Halt latch |

## Verification
If the enable flags or the shadow are wrong, the fault shows on the very next boundary: `outcome_o` names an acceptance where a fetch was due, or the other way round, and the `done_o` of that boundary carries it. If the non-maskable latch is wrong, it shows as a missing or repeated outcome 2 while the line is held high. If the sequence state is wrong, it shows during the acceptance itself, as a wrong op, address or write byte on the bus, or as a wrong `pc_o` or `sp_o` at `done_o`. If the halt latch is wrong, it shows as outcome 1 when the core should fetch, or outcome 0 when it should idle, and `halted_o` shows it one cycle after the step.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    OUT_FETCH   = 3'd0,
    OUT_HALTNOP = 3'd1,
    OUT_NMI     = 3'd2,
    OUT_MODE1   = 3'd3,
    OUT_MODE2   = 3'd4,
    OUT_MODE0   = 3'd5
  } outcome_e;

  typedef enum logic [1:0] {
    BOP_RD  = 2'd0,
    BOP_WR  = 2'd1,
    BOP_VEC = 2'd2,
    BOP_OPF = 2'd3
  } busop_e;

  localparam int TS_FETCH   = 0;
  localparam int TS_HALTNOP = 4;
  localparam int TS_MODE0   = 2;
  localparam int TS_NMI     = 11;
  localparam int TS_MODE1   = 13;
  localparam int TS_MODE2   = 19;

  function automatic logic is_accept(outcome_e o);
    return (o != OUT_FETCH) && (o != OUT_HALTNOP);
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       nmi_req_i,
  input  logic       int_req_i,
  input  logic       ei_done_i,
  input  logic       di_done_i,
  input  logic       halt_done_i,
  input  logic       im_wr_i,
  input  logic [1:0] im_val_i,
  output outcome_e   take_o,
  output logic       iff1_o,
  output logic       iff2_o,
  output logic [1:0] im_o,
  output logic       halted_o
);

  logic       nmi_prev_q, nmi_pend_q, iff1_q, iff2_q, halt_q;
  logic       nmi_pend_d, iff1_d, iff2_d, halt_d;
  logic [1:0] im_q, im_d;
  logic       nmi_rise, iff1_e, iff2_e, halt_e, accepted, maskable;
  logic [1:0] im_e;
  outcome_e   take;

  // Effective state once the completed instruction is applied
  always_comb begin
    nmi_rise = nmi_req_i & ~nmi_prev_q;
    iff1_e   = di_done_i ? 1'b0 : (ei_done_i ? 1'b1 : iff1_q);
    iff2_e   = di_done_i ? 1'b0 : (ei_done_i ? 1'b1 : iff2_q);
    im_e     = (im_wr_i && (im_val_i != 2'd3)) ? im_val_i : im_q;
    halt_e   = halt_q | halt_done_i;

    if (nmi_pend_q) begin
      take = OUT_NMI;
    end else if (int_req_i && iff1_e && !ei_done_i) begin
      case (im_e)
        2'd0:    take = OUT_MODE0;
        2'd1:    take = OUT_MODE1;
        default: take = OUT_MODE2;
      endcase
    end else if (halt_e) begin
      take = OUT_HALTNOP;
    end else begin
      take = OUT_FETCH;
    end

    accepted = is_accept(take);
    maskable = accepted && (take != OUT_NMI);
  end

  // Next state
  always_comb begin
    nmi_pend_d = nmi_pend_q | nmi_rise;
    iff1_d     = iff1_q;
    iff2_d     = iff2_q;
    im_d       = im_q;
    halt_d     = halt_q;
    if (start_i) begin
      iff1_d = accepted ? 1'b0 : iff1_e;
      iff2_d = maskable ? 1'b0 : iff2_e;
      im_d   = im_e;
      halt_d = accepted ? 1'b0 : halt_e;
      if (take == OUT_NMI) nmi_pend_d = nmi_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      iff1_q     <= 1'b0;
      iff2_q     <= 1'b0;
      im_q       <= 2'd0;
      halt_q     <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_req_i;
      nmi_pend_q <= nmi_pend_d;
      iff1_q     <= iff1_d;
      iff2_q     <= iff2_d;
      im_q       <= im_d;
      halt_q     <= halt_d;
    end
  end

  assign take_o   = take;
  assign iff1_o   = iff1_q;
  assign iff2_o   = iff2_q;
  assign im_o     = im_q;
  assign halted_o = halt_q;

endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
  import irq_seq_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              TS_W    = 5,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [ADDR_W-1:0] M1_VEC  = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  outcome_e          take_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W/2-1:0] i_reg_i,
  input  logic [7:0]        r_i,
  input  logic              bus_ack_i,
  input  logic [ADDR_W/2-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [ADDR_W/2-1:0] bus_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        outcome_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [7:0]        r_o,
  output logic [TS_W-1:0]   tstates_o
);

  localparam int DW = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_DUMMY, S_PUSH_H, S_PUSH_L, S_VEC, S_TBL_L, S_TBL_H
  } seq_st_e;

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d, tbl_q, tbl_d;
  logic [DW-1:0]     i_q, i_d;
  logic [7:0]        r_q, r_d;
  outcome_e          out_q, out_d;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic              done_q, done_d;

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    sp_d   = sp_q;
    tbl_d  = tbl_q;
    i_d    = i_q;
    r_d    = r_q;
    out_d  = out_q;
    ts_d   = ts_q;
    done_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          pc_d  = pc_i;
          sp_d  = sp_i;
          i_d   = i_reg_i;
          out_d = take_i;
          r_d   = is_accept(take_i) ? {r_i[7], r_i[6:0] + 7'd1} : r_i;
          case (take_i)
            OUT_NMI:     begin st_d = S_DUMMY;  ts_d = TS_W'(TS_NMI);   end
            OUT_MODE1:   begin st_d = S_PUSH_H; ts_d = TS_W'(TS_MODE1); end
            OUT_MODE2:   begin st_d = S_PUSH_H; ts_d = TS_W'(TS_MODE2); end
            OUT_MODE0:   begin done_d = 1'b1;   ts_d = TS_W'(TS_MODE0); end
            OUT_HALTNOP: begin done_d = 1'b1;   ts_d = TS_W'(TS_HALTNOP); end
            default:     begin done_d = 1'b1;   ts_d = TS_W'(TS_FETCH); end
          endcase
        end
      end
      S_DUMMY:  if (bus_ack_i) st_d = S_PUSH_H;
      S_PUSH_H: if (bus_ack_i) begin sp_d = sp_q - ONE; st_d = S_PUSH_L; end
      S_PUSH_L: begin
        if (bus_ack_i) begin
          sp_d = sp_q - ONE;
          if (out_q == OUT_MODE2) begin
            st_d = S_VEC;
          end else begin
            pc_d   = (out_q == OUT_NMI) ? NMI_VEC : M1_VEC;
            st_d   = S_IDLE;
            done_d = 1'b1;
          end
        end
      end
      S_VEC: begin
        if (bus_ack_i) begin
          tbl_d = {i_q, bus_rdata_i[DW-1:1], 1'b0};
          st_d  = S_TBL_L;
        end
      end
      S_TBL_L: begin
        if (bus_ack_i) begin
          pc_d[DW-1:0] = bus_rdata_i;
          st_d         = S_TBL_H;
        end
      end
      S_TBL_H: begin
        if (bus_ack_i) begin
          pc_d[ADDR_W-1:DW] = bus_rdata_i;
          st_d              = S_IDLE;
          done_d            = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // Bus request decode
  always_comb begin
    bus_req_o   = (st_q != S_IDLE);
    bus_op_o    = BOP_RD;
    bus_addr_o  = pc_q;
    bus_wdata_o = '0;
    case (st_q)
      S_DUMMY:  bus_op_o = BOP_OPF;
      S_PUSH_H: begin
        bus_op_o    = BOP_WR;
        bus_addr_o  = sp_q - ONE;
        bus_wdata_o = pc_q[ADDR_W-1:DW];
      end
      S_PUSH_L: begin
        bus_op_o    = BOP_WR;
        bus_addr_o  = sp_q - ONE;
        bus_wdata_o = pc_q[DW-1:0];
      end
      S_VEC:   bus_op_o = BOP_VEC;
      S_TBL_L: bus_addr_o = tbl_q;
      S_TBL_H: bus_addr_o = tbl_q + ONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pc_q   <= '0;
      sp_q   <= '0;
      tbl_q  <= '0;
      i_q    <= '0;
      r_q    <= '0;
      out_q  <= OUT_FETCH;
      ts_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      tbl_q  <= tbl_d;
      i_q    <= i_d;
      r_q    <= r_d;
      out_q  <= out_d;
      ts_q   <= ts_d;
      done_q <= done_d;
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign outcome_o = out_q;
  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign r_o       = r_q;
  assign tstates_o = ts_q;

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TS_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              nmi_req_i,
  input  logic              int_req_i,
  input  logic              ei_done_i,
  input  logic              di_done_i,
  input  logic              halt_done_i,
  input  logic              im_wr_i,
  input  logic [1:0]        im_val_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W/2-1:0] i_reg_i,
  input  logic [7:0]        r_i,
  output logic              bus_req_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [ADDR_W/2-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [ADDR_W/2-1:0] bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        outcome_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [7:0]        r_o,
  output logic [TS_W-1:0]   tstates_o,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic [1:0]        im_o,
  output logic              halted_o
);

  logic     start;
  outcome_e take;

  assign start = step_i & ~busy_o;

  irq_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .nmi_req_i   (nmi_req_i),
    .int_req_i   (int_req_i),
    .ei_done_i   (ei_done_i),
    .di_done_i   (di_done_i),
    .halt_done_i (halt_done_i),
    .im_wr_i     (im_wr_i),
    .im_val_i    (im_val_i),
    .take_o      (take),
    .iff1_o      (iff1_o),
    .iff2_o      (iff2_o),
    .im_o        (im_o),
    .halted_o    (halted_o)
  );

  irq_bus_seq #(
    .ADDR_W (ADDR_W),
    .TS_W   (TS_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .take_i      (take),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .i_reg_i     (i_reg_i),
    .r_i         (r_i),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_req_o   (bus_req_o),
    .bus_op_o    (bus_op_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .outcome_o   (outcome_o),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .r_o         (r_o),
    .tstates_o   (tstates_o)
  );

endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int TS_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic              ei_done_i,
  input logic              di_done_i,
  input logic              bus_req_o,
  input logic [1:0]        bus_op_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [2:0]        outcome_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [TS_W-1:0]   tstates_o,
  input logic              iff1_o,
  input logic              iff2_o,
  input logic [1:0]        im_o,
  input logic              halted_o
);

  AST_EI_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !busy_o && ei_done_i) |=> (outcome_o < 3'd3)); // R2

  AST_HALT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o >= 3'd2) |-> !halted_o); // R3

  AST_NMI_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 3'd2) |-> (pc_o == 16'h0066 && tstates_o == 5'd11 && !iff1_o)); // R4

  AST_MODE1_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 3'd3) |-> (pc_o == 16'h0038 && tstates_o == 5'd13)); // R5

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_op_o))); // R6

  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !busy_o && di_done_i) |=> (!iff1_o && !iff2_o)); // R10

  AST_HALT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 3'd1) |-> (halted_o && tstates_o == 5'd4)); // R11

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    im_o != 2'd3); // R12

endmodule

bind irq_accept_seq irq_accept_seq_chk #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_chk (.*);

// File: tb/irq_accept_seq_bench.sv
module irq_accept_seq_bench;

  logic        clk, rst_n, step_i, nmi_req_i, int_req_i;
  logic        ei_done_i, di_done_i, halt_done_i, im_wr_i;
  logic [1:0]  im_val_i;
  logic [15:0] pc_i, sp_i;
  logic [7:0]  i_reg_i, r_i;
  logic        bus_req_o, bus_ack_i;
  logic [1:0]  bus_op_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o, bus_rdata_i;
  logic        busy_o, done_o;
  logic [2:0]  outcome_o;
  logic [15:0] pc_o, sp_o;
  logic [7:0]  r_o;
  logic [4:0]  tstates_o;
  logic        iff1_o, iff2_o, halted_o;
  logic [1:0]  im_o;

  int checks = 0;
  int errors = 0;
  int n_ops;
  logic [1:0]  op_log   [8];
  logic [15:0] addr_log [8];
  logic [7:0]  data_log [8];
  logic [7:0]  vec_byte;

  irq_accept_seq u_irq_accept_seq (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Memory model: reads return low address byte xor 0x5A
  function automatic logic [7:0] rd_model(input logic [1:0] op, input logic [15:0] a);
    if (op == 2'd2) return vec_byte;
    if (op == 2'd3) return 8'h00;
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic do_step(input logic ei, input logic di, input logic hlt,
                         input logic imw, input logic [1:0] imv, input logic irq);
    bit seen;
    seen  = 0;
    n_ops = 0;
    @(negedge clk);
    step_i = 1; ei_done_i = ei; di_done_i = di; halt_done_i = hlt;
    im_wr_i = imw; im_val_i = imv; int_req_i = irq;
    @(negedge clk);
    step_i = 0; ei_done_i = 0; di_done_i = 0; halt_done_i = 0; im_wr_i = 0;
    for (int k = 0; k < 200; k++) begin
      if (done_o) begin seen = 1; break; end
      if (bus_req_o) begin
        if (n_ops < 8) begin
          op_log[n_ops] = bus_op_o; addr_log[n_ops] = bus_addr_o; data_log[n_ops] = bus_wdata_o;
        end
        n_ops++;
        bus_ack_i = 1; bus_rdata_i = rd_model(bus_op_o, bus_addr_o);
      end else begin
        bus_ack_i = 0;
      end
      @(negedge clk);
      bus_ack_i = 0;
    end
    int_req_i = 0;
    if (!seen) check("R13 done pulse timeout", 0, 1);
  endtask

  task automatic t_reset;
    check("R10 reset iff1", iff1_o, 0);
    check("R10 reset iff2", iff2_o, 0);
    check("R10 reset mode", im_o, 0);
    check("R11 reset halted", halted_o, 0);
    check("R6 reset bus_req", bus_req_o, 0);
    check("R13 reset done", done_o, 0);
  endtask

  task automatic t_plain_and_mode;
    pc_i = 16'h1234; r_i = 8'h9F;
    do_step(0, 0, 0, 1, 2'd1, 1);          // iff1 clear: irq refused
    check("R2 refused outcome", outcome_o, 0);
    check("R13 fetch tstates", tstates_o, 0);
    check("R9 r unchanged on fetch", r_o, 8'h9F);
    check("R12 mode set to 1", im_o, 1);
    do_step(0, 0, 0, 1, 2'd3, 0);
    check("R12 mode 3 ignored", im_o, 1);
  endtask

  task automatic t_mode1;
    pc_i = 16'hABCD; sp_i = 16'h8000; r_i = 8'hFF;
    do_step(1, 0, 0, 0, 2'd0, 1);          // enable shadow blocks
    check("R2 shadow outcome", outcome_o, 0);
    check("R10 ei iff1", iff1_o, 1);
    check("R10 ei iff2", iff2_o, 1);
    do_step(0, 0, 0, 0, 2'd0, 1);
    check("R5 outcome", outcome_o, 3);
    check("R5 pc", pc_o, 16'h0038);
    check("R5 tstates", tstates_o, 13);
    check("R6 op count", n_ops, 2);
    check("R6 hi addr", addr_log[0], 16'h7FFF);
    check("R6 hi data", data_log[0], 8'hAB);
    check("R6 lo addr", addr_log[1], 16'h7FFE);
    check("R6 lo data", data_log[1], 8'hCD);
    check("R6 write op", op_log[1], 1);
    check("R6 sp", sp_o, 16'h7FFE);
    check("R9 r wrap keeps bit7", r_o, 8'h80);
    check("R10 accept clears iff1", iff1_o, 0);
    check("R10 accept clears iff2", iff2_o, 0);
  endtask

  task automatic t_mode2;
    pc_i = 16'h4000; sp_i = 16'h9000; r_i = 8'h85; i_reg_i = 8'h12; vec_byte = 8'h37;
    do_step(1, 0, 0, 1, 2'd2, 0);
    do_step(0, 0, 0, 0, 2'd0, 1);
    check("R7 outcome", outcome_o, 4);
    check("R7 op count", n_ops, 5);
    check("R7 vector op", op_log[2], 2);
    check("R7 table low addr", addr_log[3], 16'h1236);
    check("R7 table high addr", addr_log[4], 16'h1237);
    check("R7 pc", pc_o, 16'h6D6C);
    check("R7 tstates", tstates_o, 19);
    check("R9 r increment", r_o, 8'h86);
  endtask

  task automatic t_nmi;
    pc_i = 16'h2222; sp_i = 16'h0100; r_i = 8'h10;
    do_step(1, 0, 0, 0, 2'd0, 0);
    @(negedge clk); nmi_req_i = 1;
    @(negedge clk);
    do_step(0, 0, 0, 0, 2'd0, 1);
    check("R1 nmi wins", outcome_o, 2);
    check("R4 dummy fetch op", op_log[0], 3);
    check("R4 dummy fetch addr", addr_log[0], 16'h2222);
    check("R4 pc", pc_o, 16'h0066);
    check("R4 tstates", tstates_o, 11);
    check("R4 iff1 cleared", iff1_o, 0);
    check("R4 iff2 kept", iff2_o, 1);
    check("R6 nmi sp", sp_o, 16'h00FE);
    do_step(0, 0, 0, 0, 2'd0, 0);
    check("R1 held line no repeat", outcome_o, 0);
    @(negedge clk); nmi_req_i = 0;
    @(negedge clk); nmi_req_i = 1;
    @(negedge clk);
    do_step(0, 0, 0, 0, 2'd0, 0);
    check("R1 new edge accepted", outcome_o, 2);
    nmi_req_i = 0;
  endtask

  task automatic t_halt;
    pc_i = 16'h0555; sp_i = 16'h8000;
    do_step(0, 0, 1, 0, 2'd0, 0);
    check("R11 halt outcome", outcome_o, 1);
    check("R11 halt pc", pc_o, 16'h0555);
    check("R11 halt tstates", tstates_o, 4);
    check("R11 halted", halted_o, 1);
    do_step(0, 0, 0, 0, 2'd0, 0);
    check("R11 still halted", outcome_o, 1);
    do_step(1, 0, 0, 1, 2'd1, 0);
    do_step(0, 0, 0, 0, 2'd0, 1);
    check("R3 accept outcome", outcome_o, 3);
    check("R3 halt cleared", halted_o, 0);
  endtask

  task automatic t_mode0_and_di;
    pc_i = 16'h3131; r_i = 8'h7F;
    do_step(1, 0, 0, 1, 2'd0, 0);
    do_step(0, 0, 0, 0, 2'd0, 1);
    check("R8 outcome", outcome_o, 5);
    check("R8 no bus", n_ops, 0);
    check("R8 tstates", tstates_o, 2);
    check("R8 pc", pc_o, 16'h3131);
    check("R9 r wrap bit7 clear", r_o, 8'h00);
    do_step(1, 0, 0, 0, 2'd0, 0);
    do_step(0, 1, 0, 0, 2'd0, 1);
    check("R10 di iff1", iff1_o, 0);
    check("R10 di iff2", iff2_o, 0);
    check("R2 di refuses", outcome_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; step_i = 0; nmi_req_i = 0; int_req_i = 0;
    ei_done_i = 0; di_done_i = 0; halt_done_i = 0; im_wr_i = 0; im_val_i = 0;
    pc_i = 0; sp_i = 0; i_reg_i = 0; r_i = 0; bus_ack_i = 0; bus_rdata_i = 0; vec_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain_and_mode();
    t_mode1();
    t_mode2();
    t_nmi();
    t_halt();
    t_mode0_and_di();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule